// File: doc/BRIEF.md
# Memory-Mapped Pin Port With Set and Clear Aliases

This block is a bank of up to 32 general-purpose pins controlled through a simple 32-bit register bus. Seven per-pin control arrays hold the output data, interrupt mask, pull-up disable, alternate-function enable, function select, direction and trigger bits. Every array can be read, and it also has two write aliases: a write-one-to-set alias and a write-one-to-clear alias. Software can therefore change any group of pins with one write and never needs a read-modify-write sequence.

On the pad side, the block synchronizes the pad inputs through two flops and presents them as a read-only pin-level word. It drives output data and output enable for pins in plain GPIO mode, and drives an active-high pull-up enable. It encodes a two-bit alternate-function code for each pin from the function, select and trigger bits. A read-only pending word reflects the vector supplied by an external edge/level detector. The mask array is exported for that detector.

Top module: `pin_port_ctrl`

## Requirements
- R1: Address decode uses `busAddr[7:4]` as the group and `busAddr[3:2]` as the alias. Group 0 reads the pin level and group 8 reads the pending word. Groups 1 to 7 are, in order, data, mask, pull, function, select, direction and trigger. Alias 0 reads, alias 1 sets and alias 2 clears. Alias 3, groups 9 to 15, and any address with bits above bit 7 set read as zero. Bits 1:0 of the address are ignored.
- R2: A write to a set alias ORs the write word into its array. Zero bits leave those pins unchanged.
- R3: A write to a clear alias ANDs the inverted write word into its array. Zero bits leave those pins unchanged.
- R4: A read of the read, set or clear alias of an array returns the current array value, with no wait state. Writes to group 0, to group 8, to alias 3 or to unused groups change nothing.
- R5: After reset, the mask and pull arrays are all ones on implemented pins and every other array is zero.
- R6: `altCode` bits [2i+1:2i] give the mode of pin i. The code is 0 when its function bit is clear. When the function bit is set, the code is 1 for select=0, 2 for select=1 with trigger=0, and 3 for select=1 with trigger=1.
- R7: The pull bit is inverted at the pad: `pullUpEn[i]` is 1 exactly when pull bit i is 0.
- R8: `padOut` follows the data array. `padOe[i]` is the direction bit (1 = output) and is forced to 0 while the function bit of pin i is set.
- R9: `padIn` passes through two flops. A value present at rising edge k is returned at group 0 after edge k+1, whatever the direction bits are.
- R10: Group 8 returns the current `pendIn` vector combinationally.
- R11: The pin count is the parameter `NPINS`. Read bits at and above `NPINS` are zero, and write bits there are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| busAddr | input | ADDR_W | Byte address of the register word |
| busWe | input | 1 | Write strobe, sampled on the rising edge |
| busWdata | input | DW | Write word |
| busRdata | output | DW | Read word for `busAddr`, combinational |
| padIn | input | NPINS | Raw pad input levels |
| pendIn | input | NPINS | Pending flags from the external detector |
| padOut | output | NPINS | Output data to the pads |
| padOe | output | NPINS | Output enable to the pads |
| pullUpEn | output | NPINS | Pull-up enable, active high |
| altCode | output | 2*NPINS | Per-pin mode code |
| irqMask | output | NPINS | Interrupt mask bits (1 = masked) |

## Verification
Read data is combinational, so a read is compared in the same cycle its address is applied. A write becomes visible on the pad outputs and in read-back from the first clock edge after it. The bench drives inputs one nanosecond after a rising edge and compares every output on the falling edge against a behavioural model that commits writes on rising edges. The pin-level result is due two edges after a pad change, and a directed check looks for the old value after one edge and the new one after two. The pending word has no latency and is compared in the cycle it is driven.

// File: rtl/pinport_pkg.sv
package pinport_pkg;
  localparam int NUM_ARR = 7;

  localparam int IDX_DATA = 1;
  localparam int IDX_MASK = 2;
  localparam int IDX_PULL = 3;
  localparam int IDX_FUNC = 4;
  localparam int IDX_SEL  = 5;
  localparam int IDX_DIR  = 6;
  localparam int IDX_TRIG = 7;

  localparam logic [3:0] GRP_PIN  = 4'h0;
  localparam logic [3:0] GRP_FLAG = 4'h8;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_NONE = 2'd3
  } aliasOp_e;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_PIN  = 2'd1,
    SRC_ARR  = 2'd2,
    SRC_FLAG = 2'd3
  } rdSrc_e;

  typedef struct packed {
    logic [NUM_ARR:1] setStb;
    logic [NUM_ARR:1] clrStb;
    rdSrc_e           rdSrc;
    logic [2:0]       rdIdx;
  } regStrobe_t;
endpackage

// File: rtl/pinport_decode.sv
module pinport_decode
  import pinport_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output regStrobe_t        stb
);
  logic [3:0] grp;
  aliasOp_e   op;
  logic       hiClear;

  assign grp     = busAddr[7:4];
  assign op      = aliasOp_e'(busAddr[3:2]);
  assign hiClear = (busAddr >> 8) == '0;

  always_comb begin
    stb        = '0;
    stb.rdSrc  = SRC_ZERO;
    stb.rdIdx  = grp[2:0];
    if (hiClear) begin
      if (grp == GRP_PIN) begin
        stb.rdSrc = SRC_PIN;
      end else if (grp == GRP_FLAG) begin
        stb.rdSrc = SRC_FLAG;
      end else begin
        for (int i = 1; i <= NUM_ARR; i++) begin
          if (grp == 4'(i) && op != OP_NONE) begin
            stb.rdSrc = SRC_ARR;
            if (busWe && op == OP_SET) stb.setStb[i] = 1'b1;
            if (busWe && op == OP_CLR) stb.clrStb[i] = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pinport_regs.sv
module pinport_regs
  import pinport_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  regStrobe_t       stb,
  input  logic [DW-1:0]    wdata,
  input  logic [NPINS-1:0] padIn,
  input  logic [NPINS-1:0] pendIn,
  output logic [DW-1:0]    rdata,
  output logic [NPINS-1:0] dataQ,
  output logic [NPINS-1:0] maskQ,
  output logic [NPINS-1:0] pullQ,
  output logic [NPINS-1:0] funcQ,
  output logic [NPINS-1:0] selQ,
  output logic [NPINS-1:0] dirQ,
  output logic [NPINS-1:0] trigQ
);
  localparam logic [NPINS-1:0] ONES  = '1;
  localparam logic [NPINS-1:0] ZEROS = '0;

  logic [NUM_ARR:1][NPINS-1:0] arrQ;
  logic [NPINS-1:0]            syncA;
  logic [NPINS-1:0]            syncB;
  logic [NPINS-1:0]            wBits;

  assign wBits = wdata[NPINS-1:0];

  function automatic logic [NPINS-1:0] resetWord(int idx);
    return (idx == IDX_MASK || idx == IDX_PULL) ? ONES : ZEROS;
  endfunction

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 1; i <= NUM_ARR; i++) arrQ[i] <= resetWord(i);
    end else begin
      for (int i = 1; i <= NUM_ARR; i++) begin
        if (stb.setStb[i])      arrQ[i] <= arrQ[i] | wBits;
        else if (stb.clrStb[i]) arrQ[i] <= arrQ[i] & ~wBits;
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (stb.rdSrc)
      SRC_PIN:  rdata = DW'(syncB);
      SRC_FLAG: rdata = DW'(pendIn);
      SRC_ARR: begin
        for (int i = 1; i <= NUM_ARR; i++)
          if (stb.rdIdx == 3'(i)) rdata = DW'(arrQ[i]);
      end
      default:  rdata = '0;
    endcase
  end

  assign dataQ = arrQ[IDX_DATA];
  assign maskQ = arrQ[IDX_MASK];
  assign pullQ = arrQ[IDX_PULL];
  assign funcQ = arrQ[IDX_FUNC];
  assign selQ  = arrQ[IDX_SEL];
  assign dirQ  = arrQ[IDX_DIR];
  assign trigQ = arrQ[IDX_TRIG];
endmodule

// File: rtl/pinport_padmux.sv
module pinport_padmux #(
  parameter int NPINS = 32
) (
  input  logic [NPINS-1:0]   dataQ,
  input  logic [NPINS-1:0]   pullQ,
  input  logic [NPINS-1:0]   funcQ,
  input  logic [NPINS-1:0]   selQ,
  input  logic [NPINS-1:0]   dirQ,
  input  logic [NPINS-1:0]   trigQ,
  output logic [NPINS-1:0]   padOut,
  output logic [NPINS-1:0]   padOe,
  output logic [NPINS-1:0]   pullUpEn,
  output logic [2*NPINS-1:0] altCode
);
  for (genvar p = 0; p < NPINS; p++) begin : gPin
    assign padOut[p]   = dataQ[p];
    assign padOe[p]    = dirQ[p] & ~funcQ[p];
    assign pullUpEn[p] = ~pullQ[p];
    assign altCode[2*p+1 -: 2] = funcQ[p] ? {selQ[p], ~selQ[p] | trigQ[p]} : 2'b00;
  end
endmodule

// File: rtl/pin_port_ctrl.sv
module pin_port_ctrl
  import pinport_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int DW     = 32,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [DW-1:0]       busWdata,
  output logic [DW-1:0]       busRdata,
  input  logic [NPINS-1:0]    padIn,
  input  logic [NPINS-1:0]    pendIn,
  output logic [NPINS-1:0]    padOut,
  output logic [NPINS-1:0]    padOe,
  output logic [NPINS-1:0]    pullUpEn,
  output logic [2*NPINS-1:0]  altCode,
  output logic [NPINS-1:0]    irqMask
);
  regStrobe_t       stb;
  logic [NPINS-1:0] dataQ, pullQ, funcQ, selQ, dirQ, trigQ;

  pinport_decode #(.ADDR_W(ADDR_W)) uDecode (
    .busAddr (busAddr),
    .busWe   (busWe),
    .stb     (stb)
  );

  pinport_regs #(.NPINS(NPINS), .DW(DW)) uRegs (
    .clk    (clk),
    .rst    (rst),
    .stb    (stb),
    .wdata  (busWdata),
    .padIn  (padIn),
    .pendIn (pendIn),
    .rdata  (busRdata),
    .dataQ  (dataQ),
    .maskQ  (irqMask),
    .pullQ  (pullQ),
    .funcQ  (funcQ),
    .selQ   (selQ),
    .dirQ   (dirQ),
    .trigQ  (trigQ)
  );

  pinport_padmux #(.NPINS(NPINS)) uPadmux (
    .dataQ    (dataQ),
    .pullQ    (pullQ),
    .funcQ    (funcQ),
    .selQ     (selQ),
    .dirQ     (dirQ),
    .trigQ    (trigQ),
    .padOut   (padOut),
    .padOe    (padOe),
    .pullUpEn (pullUpEn),
    .altCode  (altCode)
  );
endmodule

// File: rtl/pinport_chk.sv
module pinport_chk #(
  parameter int NPINS  = 32,
  parameter int DW     = 32,
  parameter int ADDR_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWe,
  input logic [DW-1:0]      busWdata,
  input logic [DW-1:0]      busRdata,
  input logic [NPINS-1:0]   padOut,
  input logic [NPINS-1:0]   padOe,
  input logic [NPINS-1:0]   pullUpEn,
  input logic [2*NPINS-1:0] altCode,
  input logic [NPINS-1:0]   irqMask
);
  logic [NPINS-1:0] wBits;
  logic [NPINS-1:0] altActive;
  logic             wrDataSet, wrDataClr, wrReadOnly;

  assign wBits      = busWdata[NPINS-1:0];
  assign wrDataSet  = busWe && busAddr == ADDR_W'(8'h14);
  assign wrDataClr  = busWe && busAddr == ADDR_W'(8'h18);
  assign wrReadOnly = busWe && (busAddr == ADDR_W'(8'h00) || busAddr == ADDR_W'(8'h80));

  always_comb begin
    for (int p = 0; p < NPINS; p++) altActive[p] = altCode[2*p+1 -: 2] != 2'b00;
  end

  assert_set_ors_R2: assert property (@(posedge clk) disable iff (rst)
    wrDataSet |=> (padOut & $past(wBits)) == $past(wBits));

  assert_set_keeps_R2: assert property (@(posedge clk) disable iff (rst)
    wrDataSet |=> (padOut & ~$past(wBits)) == ($past(padOut) & ~$past(wBits)));

  assert_clr_ands_R3: assert property (@(posedge clk) disable iff (rst)
    wrDataClr |=> (padOut & $past(wBits)) == '0);

  assert_clr_keeps_R3: assert property (@(posedge clk) disable iff (rst)
    wrDataClr |=> (padOut & ~$past(wBits)) == ($past(padOut) & ~$past(wBits)));

  assert_ro_write_R4: assert property (@(posedge clk) disable iff (rst)
    wrReadOnly |=> $stable(padOut) && $stable(padOe) && $stable(pullUpEn)
                   && $stable(altCode) && $stable(irqMask));

  assert_alt_no_oe_R8: assert property (@(posedge clk) disable iff (rst)
    (padOe & altActive) == '0);

  if (NPINS < DW) begin : gUpper
    assert_upper_zero_R11: assert property (@(posedge clk) disable iff (rst)
      busRdata[DW-1:NPINS] == '0);
  end
endmodule

bind pin_port_ctrl pinport_chk #(.NPINS(NPINS), .DW(DW), .ADDR_W(ADDR_W)) uChk (
  .clk      (clk),
  .rst      (rst),
  .busAddr  (busAddr),
  .busWe    (busWe),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .padOut   (padOut),
  .padOe    (padOe),
  .pullUpEn (pullUpEn),
  .altCode  (altCode),
  .irqMask  (irqMask)
);

// File: tb/sim_pin_port_ctrl.sv
`timescale 1ns/1ps
module sim_pin_port_ctrl;
  localparam int NP = 31;
  localparam logic [31:0] PMASK = 32'h7FFF_FFFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    busAddr = '0;
  logic          busWe = 1'b0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] pendIn = '0;
  logic [NP-1:0] padOut, padOe, pullUpEn, irqMask;
  logic [2*NP-1:0] altCode;

  int compared = 0;
  int mismatched = 0;
  bit started = 0;
  bit done = 0;

  logic [31:0] arr [1:7];
  logic [31:0] s1, s2;

  always #2.5 clk = ~clk;

  pin_port_ctrl #(.NPINS(NP), .DW(32), .ADDR_W(8)) u0 (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .padIn(padIn), .pendIn(pendIn), .padOut(padOut),
    .padOe(padOe), .pullUpEn(pullUpEn), .altCode(altCode), .irqMask(irqMask)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model: commits on rising edges
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i <= 7; i++) arr[i] = 32'h0;
      arr[2] = PMASK;
      arr[3] = PMASK;
      s1 = 0;
      s2 = 0;
    end else begin
      s2 = s1;
      s1 = 32'(padIn);
      if (busWe && busAddr[7:4] >= 4'd1 && busAddr[7:4] <= 4'd7) begin
        if (busAddr[3:2] == 2'd1) arr[busAddr[7:4]] = (arr[busAddr[7:4]] | busWdata) & PMASK;
        if (busAddr[3:2] == 2'd2) arr[busAddr[7:4]] = arr[busAddr[7:4]] & ~busWdata;
      end
    end
  end

  function automatic logic [31:0] expRd(logic [7:0] a);
    if (a[7:4] == 4'd0) return s2;
    if (a[7:4] == 4'd8) return 32'(pendIn);
    if (a[7:4] >= 4'd1 && a[7:4] <= 4'd7 && a[3:2] != 2'd3) return arr[a[7:4]];
    return 32'h0;
  endfunction

  function automatic logic [63:0] expAlt();
    logic [63:0] v = '0;
    for (int p = 0; p < NP; p++)
      if (arr[4][p]) v[2*p +: 2] = arr[5][p] ? (arr[7][p] ? 2'd3 : 2'd2) : 2'd1;
    return v;
  endfunction

  // every-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (started && !rst) begin
      chk("R1 R4 busRdata", 64'(busRdata), 64'(expRd(busAddr)));
      chk("R8 padOut", 64'(padOut), 64'(arr[1]));
      chk("R8 padOe", 64'(padOe), 64'(arr[6] & ~arr[4]));
      chk("R7 pullUpEn", 64'(pullUpEn), 64'(~arr[3] & PMASK));
      chk("R6 altCode", 64'(altCode), expAlt());
      chk("R5 irqMask", 64'(irqMask), 64'(arr[2]));
    end
  end

  task automatic step(logic [7:0] a, logic we, logic [31:0] wd);
    @(posedge clk); #1;
    busAddr = a; busWe = we; busWdata = wd;
  endtask

  task automatic rd(logic [7:0] a);
    step(a, 1'b0, 32'h0);
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    started = 1;
    // R5 reset values, R11 unimplemented bit 31 reads zero
    rd(8'h30); chk("R5 pull reset", 64'(busRdata), 64'h7FFF_FFFF);
    rd(8'h20); chk("R5 mask reset", 64'(busRdata), 64'h7FFF_FFFF);
    rd(8'h10); chk("R5 data reset", 64'(busRdata), 64'h0);
    chk("R5 padOe reset", 64'(padOe), 64'h0);
    // R2 set alias, R11 upper bit ignored
    step(8'h14, 1'b1, 32'hFFFF_00F0);
    rd(8'h10); chk("R2 R11 data set", 64'(busRdata), 64'h7FFF_00F0);
    rd(8'h14); chk("R4 read via set alias", 64'(busRdata), 64'h7FFF_00F0);
    // R3 clear alias
    step(8'h18, 1'b1, 32'h0000_0030);
    rd(8'h18); chk("R3 data clear", 64'(busRdata), 64'h7FFF_00C0);
    chk("R8 padOut data", 64'(padOut), 64'h7FFF_00C0);
    // R4 writes to read-only groups and alias 3 ignored
    step(8'h00, 1'b1, 32'hFFFF_FFFF);
    step(8'h80, 1'b1, 32'hFFFF_FFFF);
    step(8'h1C, 1'b1, 32'hFFFF_FFFF);
    rd(8'h10); chk("R4 ignored writes", 64'(busRdata), 64'h7FFF_00C0);
    rd(8'h1C); chk("R1 alias 3 reads zero", 64'(busRdata), 64'h0);
    rd(8'h90); chk("R1 unused group zero", 64'(busRdata), 64'h0);
    // R8 direction and function override
    step(8'h64, 1'b1, 32'h0000_00FF);
    rd(8'h60); chk("R8 padOe dir", 64'(padOe), 64'hFF);
    step(8'h44, 1'b1, 32'h0000_000F);
    step(8'h54, 1'b1, 32'h0000_000C);
    step(8'h74, 1'b1, 32'h0000_0018);
    rd(8'h70);
    chk("R8 padOe func", 64'(padOe), 64'hF0);
    chk("R6 altCode modes", 64'(altCode), 64'hE5);
    // R7 pull polarity
    step(8'h38, 1'b1, 32'h0000_0003);
    rd(8'h30);
    chk("R7 pull read", 64'(busRdata), 64'h7FFF_FFFC);
    chk("R7 pullUpEn", 64'(pullUpEn), 64'h3);
    // R9 two-flop pin level, independent of direction
    step(8'h00, 1'b0, 32'h0);
    padIn = 31'h25A5_A5A5;
    @(negedge clk);
    @(negedge clk); chk("R9 one edge old", 64'(busRdata), 64'h0);
    @(negedge clk); chk("R9 two edges new", 64'(busRdata), 64'h25A5_A5A5);
    // R10 pending word
    step(8'h80, 1'b0, 32'h0);
    pendIn = 31'h7FFF_0001;
    @(negedge clk); chk("R10 pending", 64'(busRdata), 64'h7FFF_0001);
    // random traffic compared each cycle against the model
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] g;
      g = 4'($urandom_range(0, 9));
      step({g, 2'($urandom_range(0, 3)), 2'b00}, 1'($urandom_range(0, 1)), $urandom);
      if (n % 3 == 0) padIn = NP'($urandom);
      if (n % 5 == 0) pendIn = NP'($urandom);
    end
    step(8'h00, 1'b0, 32'h0);
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule